// File: doc/BRIEF.md
# Pixel Reset Timestamp and Interval Capture

This block is the digital back end of one charge-integrate/reset pixel channel. A comparator watches the integrating amplifier and delivers a synchronous threshold flag. The block samples that flag on every rising clock edge. When the flag is seen while the channel is armed, three things happen. The channel drives a reset pulse to the analog integrator. It latches the value of a free-running timestamp counter. It works out the elapsed count since the previous capture.

Each capture becomes one record: a first-event flag, the timestamp and the interval. Records go into a small FIFO, which a readout port drains with a valid/ready handshake. The interval between resets measures how fast charge arrives at the pixel. The block only produces ordered records; any interpretation of them is left to downstream logic.

After each capture the channel ignores the comparator for the length of the reset pulse plus one cycle. It then re-arms on its own. A synchronous clear restarts the time base and discards buffered records.

Top module: `pixcap_top`

## Requirements
- R1: While armed and enabled, a high `cmpHit` sampled at a rising edge creates a capture at that edge. The recorded stamp is the counter value in that cycle. If `clear` is high at edge e and the capture edge is e+n, the stamp is n-1.
- R2: `intReset` goes high in the cycle after the capture edge and stays high for exactly `RST_CYC` cycles (default 4).
- R3: `cmpHit` has no effect while `intReset` is high or in the one cycle after it. A `cmpHit` held high therefore captures once every `RST_CYC`+2 cycles.
- R4: `outGap` is the stamp minus the previous capture's stamp, taken modulo 2^`TS_W`. The result is correct across a counter wrap.
- R5: The first capture after `rstN` reset, after `clear`, or after any cycle with `enable` low has `outFirst` = 1 and `outGap` = 0. Every other record has `outFirst` = 0.
- R6: Records leave in capture order. The FIFO holds `DEPTH` (default 8) records. While `outValid` is high and `outReady` is low, the head record stays unchanged.
- R7: A capture that finds the FIFO full is discarded. It sets the sticky `overflow` flag and increments `dropCount`, which saturates. `intReset` is still issued for that capture.
- R8: When `clear` is high at a rising edge, the counter is zeroed, the FIFO is emptied, `overflow` and `dropCount` are cleared, and the next capture is marked first.
- R9: While `enable` is low, no capture occurs and `intReset` is not raised.
- R10: After `rstN` is asserted, `outValid`, `intReset` and `overflow` are 0 and `dropCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timestamp counter advances on each rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows captures when high |
| clear | input | 1 | Synchronous active-high restart of time base, FIFO and overflow state |
| cmpHit | input | 1 | Synchronous comparator threshold flag |
| intReset | output | 1 | Reset pulse to the analog integrator |
| outValid | output | 1 | Head record available |
| outReady | input | 1 | Consumer accepts the head record |
| outFirst | output | 1 | Head record has no predecessor |
| outStamp | output | TS_W | Head record timestamp |
| outGap | output | TS_W | Head record interval since the previous capture |
| overflow | output | 1 | Sticky flag: a record was dropped |
| dropCount | output | DROP_W | Number of dropped records, saturating |

## Verification
Two situations are hard to reach from the ports: a counter wrap between two captures, and a FIFO overflow that still has to pulse the integrator. A 32-bit wrap would take billions of cycles. The bench therefore runs a second instance with an 8-bit counter on the same stimulus and places two captures on either side of the wrap point. Overflow is reached by holding the comparator flag high with the reader stalled until ten captures have occurred. The bench counts the integrator pulses, so it sees the two dropped captures still produce resets.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PULSE = 2'd1,
    ST_GUARD = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic capture;     // take a timestamp this cycle
    logic wipe;        // synchronous restart
    logic rearmFirst;  // next capture has no predecessor
  } capStrobe_t;

endpackage

// File: rtl/pixcap_ctrl.sv
module pixcap_ctrl
  import pixcap_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       clear,
  input  logic       cmpHit,
  output logic       intReset,
  output capStrobe_t strb
);

  localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] pulseCnt;

  always_comb begin
    strb.capture    = (state == ST_ARMED) && enable && cmpHit && !clear;
    strb.wipe       = clear;
    strb.rearmFirst = !enable;
  end

  assign intReset = (state == ST_PULSE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARMED;
      pulseCnt <= '0;
    end else if (clear) begin
      state    <= ST_ARMED;
      pulseCnt <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          pulseCnt <= '0;
          if (strb.capture) state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (pulseCnt == LAST) begin
            state    <= ST_GUARD;
            pulseCnt <= '0;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
        ST_GUARD: state <= ST_ARMED;
        default:  state <= ST_ARMED;
      endcase
    end
  end

endmodule

// File: rtl/pixcap_dp.sv
module pixcap_dp
  import pixcap_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int DEPTH  = 8,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strb,
  input  logic              outReady,
  output logic              outValid,
  output logic              outFirst,
  output logic [TS_W-1:0]   outStamp,
  output logic [TS_W-1:0]   outGap,
  output logic              overflow,
  output logic [DROP_W-1:0] dropCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [TS_W-1:0] tsCounter;
  logic [TS_W-1:0] lastStamp;
  logic            firstPend;

  logic            memFirst [DEPTH];
  logic [TS_W-1:0] memStamp [DEPTH];
  logic [TS_W-1:0] memGap   [DEPTH];

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill;
  logic full, push, pop, drop;
  logic [TS_W-1:0] newGap;

  assign full   = (fill == FULL_LVL);
  assign push   = strb.capture && !full;
  assign drop   = strb.capture && full;
  assign pop    = outValid && outReady;
  assign newGap = firstPend ? '0 : (tsCounter - lastStamp);

  assign outValid = (fill != '0);
  assign outFirst = memFirst[rdPtr];
  assign outStamp = memStamp[rdPtr];
  assign outGap   = memGap[rdPtr];

  // time base and predecessor tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsCounter <= '0;
      lastStamp <= '0;
      firstPend <= 1'b1;
    end else if (strb.wipe) begin
      tsCounter <= '0;
      lastStamp <= '0;
      firstPend <= 1'b1;
    end else begin
      tsCounter <= tsCounter + 1'b1;
      if (strb.capture) begin
        lastStamp <= tsCounter;
        firstPend <= 1'b0;
      end else if (strb.rearmFirst) begin
        firstPend <= 1'b1;
      end
    end
  end

  // record storage
  always_ff @(posedge clk) begin
    if (push) begin
      memFirst[wrPtr] <= firstPend;
      memStamp[wrPtr] <= tsCounter;
      memGap[wrPtr]   <= newGap;
    end
  end

  // pointers, fill level and drop accounting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      overflow  <= 1'b0;
      dropCount <= '0;
    end else if (strb.wipe) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      overflow  <= 1'b0;
      dropCount <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (drop) begin
        overflow <= 1'b1;
        if (dropCount != '1) dropCount <= dropCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pixcap_top.sv
module pixcap_top
  import pixcap_pkg::*;
#(
  parameter int TS_W    = 32,
  parameter int DEPTH   = 8,
  parameter int RST_CYC = 4,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              clear,
  input  logic              cmpHit,
  output logic              intReset,
  output logic              outValid,
  input  logic              outReady,
  output logic              outFirst,
  output logic [TS_W-1:0]   outStamp,
  output logic [TS_W-1:0]   outGap,
  output logic              overflow,
  output logic [DROP_W-1:0] dropCount
);

  capStrobe_t strb;

  pixcap_ctrl #(.RST_CYC(RST_CYC)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .clear    (clear),
    .cmpHit   (cmpHit),
    .intReset (intReset),
    .strb     (strb)
  );

  pixcap_dp #(.TS_W(TS_W), .DEPTH(DEPTH), .DROP_W(DROP_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .outReady  (outReady),
    .outValid  (outValid),
    .outFirst  (outFirst),
    .outStamp  (outStamp),
    .outGap    (outGap),
    .overflow  (overflow),
    .dropCount (dropCount)
  );

endmodule

// File: rtl/pixcap_chk.sv
module pixcap_chk #(
  parameter int TS_W    = 32,
  parameter int RST_CYC = 4,
  parameter int DROP_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              clear,
  input logic              cmpHit,
  input logic              intReset,
  input logic              outValid,
  input logic              outReady,
  input logic              outFirst,
  input logic [TS_W-1:0]   outStamp,
  input logic [TS_W-1:0]   outGap,
  input logic              overflow,
  input logic [DROP_W-1:0] dropCount
);

  logic [31:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         hiCnt <= '0;
    else if (intReset) hiCnt <= hiCnt + 1'b1;
    else               hiCnt <= '0;
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReset |-> (hiCnt < 32'(RST_CYC)));

  // R3
  guard_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(intReset) && !$past(clear)) |=> !intReset);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReset) |-> $past(enable && cmpHit && !clear));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !clear) |=>
      (outValid && $stable(outStamp) && $stable(outGap) && $stable(outFirst)));

  // R5
  first_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirst) |-> (outGap == '0));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clear) |=> overflow);

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!outValid && !overflow && (dropCount == '0)));

endmodule

bind pixcap_top pixcap_chk #(.TS_W(TS_W), .RST_CYC(RST_CYC), .DROP_W(DROP_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .clear     (clear),
  .cmpHit    (cmpHit),
  .intReset  (intReset),
  .outValid  (outValid),
  .outReady  (outReady),
  .outFirst  (outFirst),
  .outStamp  (outStamp),
  .outGap    (outGap),
  .overflow  (overflow),
  .dropCount (dropCount)
);

// File: tb/tb_pixcap_top.sv
`timescale 1ns/1ps
module tb_pixcap_top;

  localparam int RST_CYC = 4;
  localparam int PERIOD  = RST_CYC + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic clear = 1'b0;
  logic cmpHit = 1'b0;
  logic outReady = 1'b0;

  logic        intReset, outValid, outFirst, overflow;
  logic [31:0] outStamp, outGap;
  logic [15:0] dropCount;

  logic        wIntReset, wValid, wFirst, wOverflow;
  logic [7:0]  wStamp, wGap;
  logic [15:0] wDrop;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pixcap_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .cmpHit(cmpHit),
    .intReset(intReset), .outValid(outValid), .outReady(outReady),
    .outFirst(outFirst), .outStamp(outStamp), .outGap(outGap),
    .overflow(overflow), .dropCount(dropCount)
  );

  pixcap_top #(.TS_W(8)) dutNarrow (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .cmpHit(cmpHit),
    .intReset(wIntReset), .outValid(wValid), .outReady(outReady),
    .outFirst(wFirst), .outStamp(wStamp), .outGap(wGap),
    .overflow(wOverflow), .dropCount(wDrop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearPulse();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  // wait w edges, then present cmpHit for exactly one edge
  task automatic hit(input int w);
    repeat (w) @(negedge clk);
    cmpHit = 1'b1;
    @(negedge clk) cmpHit = 1'b0;
  endtask

  task automatic popEntry(input string req, output logic f, output logic [31:0] s,
                          output logic [31:0] g);
    check({req, " valid before pop"}, 32'(outValid), 32'd1);
    f = outFirst; s = outStamp; g = outGap;
    outReady = 1'b1;
    @(negedge clk) outReady = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 outValid", 32'(outValid), 32'd0);
    check("R10 intReset", 32'(intReset), 32'd0);
    check("R10 overflow", 32'(overflow), 32'd0);
    check("R10 dropCount", 32'(dropCount), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testSingle();
    int hiCycles;
    logic f; logic [31:0] s, g;
    clearPulse();
    hit(9);
    hiCycles = 0;
    while (intReset && hiCycles < 50) begin
      hiCycles++;
      @(negedge clk);
    end
    check("R2 pulse length", 32'(hiCycles), 32'(RST_CYC));
    popEntry("R1", f, s, g);
    check("R1 stamp", s, 32'd9);
    check("R5 first flag", 32'(f), 32'd1);
    check("R5 first gap", g, 32'd0);
  endtask

  task automatic testLockout();
    logic f; logic [31:0] s, g;
    clearPulse();
    cmpHit = 1'b1;
    repeat (2 * PERIOD + 2) @(negedge clk);
    cmpHit = 1'b0;
    repeat (PERIOD) @(negedge clk);
    popEntry("R3", f, s, g);
    check("R3 first of held hit", 32'(f), 32'd1);
    popEntry("R3", f, s, g);
    check("R3 lockout gap", g, 32'(PERIOD));
    check("R5 later not first", 32'(f), 32'd0);
    popEntry("R3", f, s, g);
    check("R4 gap held hit", g, 32'(PERIOD));
    check("R3 no extra capture", 32'(outValid), 32'd0);
  endtask

  task automatic testOrderStall();
    logic f; logic [31:0] s, g;
    logic [31:0] headStamp;
    clearPulse();
    hit(3);
    hit(10);
    hit(20);
    repeat (PERIOD) @(negedge clk);
    headStamp = outStamp;
    repeat (5) @(negedge clk);
    check("R6 valid held", 32'(outValid), 32'd1);
    check("R6 head stable", outStamp, headStamp);
    popEntry("R6", f, s, g);
    check("R6 order 1 stamp", s, 32'd3);
    popEntry("R6", f, s, g);
    check("R6 order 2 stamp", s, 32'd14);
    check("R4 gap 2", g, 32'd11);
    popEntry("R6", f, s, g);
    check("R6 order 3 stamp", s, 32'd35);
    check("R4 gap 3", g, 32'd21);
  endtask

  task automatic testOverflow();
    int rises;
    logic prev;
    logic f; logic [31:0] s, g;
    clearPulse();
    rises = 0;
    prev = intReset;
    cmpHit = 1'b1;
    for (int i = 0; i < 9 * PERIOD + 4; i++) begin
      @(negedge clk);
      if (intReset && !prev) rises++;
      prev = intReset;
    end
    cmpHit = 1'b0;
    repeat (PERIOD) @(negedge clk);
    check("R7 resets incl dropped", 32'(rises), 32'd10);
    check("R7 overflow set", 32'(overflow), 32'd1);
    check("R7 drop count", 32'(dropCount), 32'd2);
    popEntry("R7", f, s, g);
    check("R7 kept oldest", 32'(f), 32'd1);
    popEntry("R7", f, s, g);
    check("R7 second kept gap", g, 32'(PERIOD));
    check("R7 overflow sticky", 32'(overflow), 32'd1);
  endtask

  task automatic testClear();
    logic f; logic [31:0] s, g;
    clearPulse();
    check("R8 fifo empty", 32'(outValid), 32'd0);
    check("R8 overflow cleared", 32'(overflow), 32'd0);
    check("R8 drops cleared", 32'(dropCount), 32'd0);
    hit(5);
    popEntry("R8", f, s, g);
    check("R8 counter restart", s, 32'd5);
    check("R8 first after clear", 32'(f), 32'd1);
  endtask

  task automatic testEnable();
    int sawPulse;
    logic f; logic [31:0] s, g;
    clearPulse();
    hit(2);
    repeat (PERIOD + 2) @(negedge clk);
    enable = 1'b0;
    cmpHit = 1'b1;
    sawPulse = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (intReset) sawPulse++;
    end
    cmpHit = 1'b0;
    enable = 1'b1;
    check("R9 no pulse disabled", 32'(sawPulse), 32'd0);
    popEntry("R9", f, s, g);
    check("R9 no capture disabled", 32'(outValid), 32'd0);
    hit(4);
    popEntry("R5", f, s, g);
    check("R5 first after enable", 32'(f), 32'd1);
    check("R5 gap after enable", g, 32'd0);
  endtask

  task automatic testWrap();
    logic [7:0] st1, st2, gp2;
    clearPulse();
    hit(200);
    hit(100);
    repeat (PERIOD) @(negedge clk);
    check("R4 narrow valid", 32'(wValid), 32'd1);
    st1 = wStamp;
    outReady = 1'b1;
    @(negedge clk);
    st2 = wStamp; gp2 = wGap;
    @(negedge clk) outReady = 1'b0;
    check("R4 pre-wrap stamp", 32'(st1), 32'd200);
    check("R4 post-wrap stamp", 32'(st2), 32'd45);
    check("R4 gap across wrap", 32'(gp2), 32'd101);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testSingle();
    testLockout();
    testOrderStall();
    testOverflow();
    testClear();
    testEnable();
    testWrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule